// File: doc/BRIEF.md
# Key-Unlocked Register Write Guard

This block sits on a byte-wide register bus (address, write data, write strobe, read data). It holds an 8-bit key register. Writes that land in a fixed set of guarded address ranges only take effect while the key register holds the unlock value, 0x96. At any other time such writes are dropped without a bus error. The guarded ranges stand in for I/O configuration and pin-multiplexing registers, and a small byte bank models them so that the effect of each write can be read back.

The block drives two qualified write strobes. One pulses for accepted writes into the guarded ranges. The other pulses for writes to ordinary, unguarded space. A sticky flag records that at least one guarded write was dropped. Software clears the flag by writing 1 to it. Reads are never blocked.

Top module: `key_write_guard`

## Requirements
- R1: After reset the key register reads 0x00, the drop flag is 0 and every guarded byte reads 0x00.
- R2: The key register at 0x30083F can be written and read back under any lock state, and it is never a guarded address.
- R3: The block is unlocked only while the key register holds exactly 0x96. Writing any other value, for example 0x95, leaves guarded writes blocked.
- R4: While the block is locked, a write to a guarded address leaves the stored byte unchanged and does not pulse `guard_we`.
- R5: The guarded addresses are exactly 0x300320 to 0x30032C, 0x300800 to 0x300819, and 0x30083E. The neighbours 0x30031F, 0x30032D, 0x3007FF, 0x30081A and 0x30083D are unguarded.
- R6: Once unlocked, any number of guarded writes are accepted. Writing a value other than 0x96 to the key register locks the block again from the next cycle.
- R7: Lock state is taken from the key register as it stood before the current cycle. A guarded write in the cycle right after the key write of 0x96 is accepted.
- R8: Reads of every address return the stored contents whether the block is locked or not. Unmapped addresses read 0x00.
- R9: `open_we` pulses, in the same cycle, for every write to an address that is not guarded and is neither the key nor the status address, whatever the lock state. `guard_we` and `open_we` are never high together.
- R10: `drop_flag` is read at bit 0 of 0x30083C. It sets on the edge that ends a dropped guarded write and then stays set. Writing a byte with bit 0 = 1 to 0x30083C clears it. Writing bit 0 = 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 24 | Byte address of the current bus cycle |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one byte per cycle |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| guard_we | output | 1 | Accepted write into a guarded range |
| open_we | output | 1 | Write into unguarded ordinary space |
| drop_flag | output | 1 | Sticky flag: a guarded write was dropped |

## Verification
The assertions assume that each cycle carries at most one byte write. They also assume that `bus_addr` and `bus_wdata` are stable across the rising edge while `bus_we` is high. The bench meets this by changing every input only on the falling edge and by issuing one operation per cycle. Cycles without a write hold `bus_we` low, so the bench can compare the read path on idle cycles without moving any state.

// File: rtl/key_write_guard.sv
module key_write_guard #(
  parameter int unsigned    AW         = 24,
  parameter logic [AW-1:0]  WIN_A_BASE = 24'h300320,
  parameter int unsigned    WIN_A_LEN  = 13,
  parameter logic [AW-1:0]  WIN_B_BASE = 24'h300800,
  parameter int unsigned    WIN_B_LEN  = 26,
  parameter logic [AW-1:0]  SOLO_ADDR  = 24'h30083E,
  parameter logic [AW-1:0]  KEY_ADDR   = 24'h30083F,
  parameter logic [AW-1:0]  STAT_ADDR  = 24'h30083C,
  parameter logic [7:0]     KEY_VALUE  = 8'h96
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  input  logic          bus_we,
  output logic [7:0]    bus_rdata,
  output logic          guard_we,
  output logic          open_we,
  output logic          drop_flag
);
  localparam int unsigned NREG = WIN_A_LEN + WIN_B_LEN + 1;
  localparam int unsigned IW   = $clog2(NREG);

  logic [7:0]    key_q;
  logic [7:0]    bank [NREG];
  logic [AW-1:0] offs_a, offs_b;
  logic          hit_a, hit_b, hit_s, in_guard, unlocked;
  logic          is_key, is_stat;
  logic [IW-1:0] idx;

  assign offs_a   = bus_addr - WIN_A_BASE;
  assign offs_b   = bus_addr - WIN_B_BASE;
  assign hit_a    = (bus_addr >= WIN_A_BASE) && (offs_a < AW'(WIN_A_LEN));
  assign hit_b    = (bus_addr >= WIN_B_BASE) && (offs_b < AW'(WIN_B_LEN));
  assign hit_s    = (bus_addr == SOLO_ADDR);
  assign in_guard = hit_a | hit_b | hit_s;
  assign is_key   = (bus_addr == KEY_ADDR);
  assign is_stat  = (bus_addr == STAT_ADDR);
  assign unlocked = (key_q == KEY_VALUE);

  assign idx = hit_a ? IW'(offs_a)
             : hit_b ? IW'(offs_b) + IW'(WIN_A_LEN)
             : IW'(NREG - 1);

  assign guard_we = bus_we & in_guard & unlocked;
  assign open_we  = bus_we & ~in_guard & ~is_key & ~is_stat;

  always_comb begin
    if (is_key)        bus_rdata = key_q;
    else if (is_stat)  bus_rdata = {7'b0, drop_flag};
    else if (in_guard) bus_rdata = bank[idx];
    else               bus_rdata = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q     <= 8'h00;
      drop_flag <= 1'b0;
    end else begin
      if (bus_we && is_key) key_q <= bus_wdata;
      if (bus_we && in_guard && !unlocked) drop_flag <= 1'b1;
      else if (bus_we && is_stat && bus_wdata[0]) drop_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(NREG); i++) bank[i] <= 8'h00;
    end else if (guard_we) begin
      bank[idx] <= bus_wdata;
    end
  end
endmodule

// File: rtl/key_write_guard_chk.sv
module key_write_guard_chk #(
  parameter int unsigned   AW        = 24,
  parameter logic [AW-1:0] KEY_ADDR  = 24'h30083F,
  parameter logic [AW-1:0] STAT_ADDR = 24'h30083C,
  parameter logic [7:0]    KEY_VALUE = 8'h96
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic [7:0]    bus_wdata,
  input logic          bus_we,
  input logic          guard_we,
  input logic          open_we,
  input logic          drop_flag,
  input logic [7:0]    key_q
);
  a_r4_no_guard_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
    guard_we |-> key_q == KEY_VALUE);

  a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(guard_we && open_we));

  a_r9_strobes_need_we: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_we || open_we) |-> bus_we);

  a_r2_key_written: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == KEY_ADDR) |=> key_q == $past(bus_wdata));

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_flag && !(bus_we && bus_addr == STAT_ADDR && bus_wdata[0])) |=> drop_flag);

  a_r10_flag_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drop_flag) |-> $past(bus_we) && !$past(guard_we) && !$past(open_we));

  a_r6_key_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == KEY_ADDR) |=> $stable(key_q));
endmodule

bind key_write_guard key_write_guard_chk #(
  .AW(AW), .KEY_ADDR(KEY_ADDR), .STAT_ADDR(STAT_ADDR), .KEY_VALUE(KEY_VALUE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .guard_we(guard_we), .open_we(open_we),
  .drop_flag(drop_flag), .key_q(key_q)
);

// File: tb/key_write_guard_test.sv
`timescale 1ns/1ps
module key_write_guard_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [23:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_we = 0;
  logic [7:0]  bus_rdata;
  logic        guard_we, open_we, drop_flag;

  int checks = 0, fails = 0;
  bit done = 0;

  byte unsigned m_mem [int];
  byte unsigned m_key = 0;
  bit           m_drop = 0;

  localparam logic [23:0] KEY = 24'h30083F, STAT = 24'h30083C;

  key_write_guard uut (.*);

  always #4 clk = ~clk;

  function automatic bit guarded(logic [23:0] a);
    return (a >= 24'h300320 && a <= 24'h30032C) ||
           (a >= 24'h300800 && a <= 24'h300819) || a == 24'h30083E;
  endfunction

  function automatic logic [7:0] exp_read(logic [23:0] a);
    if (a == KEY) return m_key;
    if (a == STAT) return {7'b0, m_drop};
    if (guarded(a)) return m_mem.exists(int'(a)) ? m_mem[int'(a)] : 8'h00;
    return 8'h00;
  endfunction

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic op(logic [23:0] a, bit we, logic [7:0] d, string req);
    bit unl, g, o;
    @(negedge clk);
    bus_addr = a; bus_we = we; bus_wdata = d;
    #2;
    unl = (m_key == 8'h96);
    g = we && guarded(a) && unl;
    o = we && !guarded(a) && a != KEY && a != STAT;
    chk(req, "rdata", bus_rdata, exp_read(a));
    chk(req, "guard_we", {7'b0, guard_we}, {7'b0, g});
    chk(req, "open_we", {7'b0, open_we}, {7'b0, o});
    chk(req, "drop_flag", {7'b0, drop_flag}, {7'b0, m_drop});
    @(posedge clk);
    if (we) begin
      if (a == KEY) m_key = d;
      if (guarded(a) && unl) m_mem[int'(a)] = d;
      if (guarded(a) && !unl) m_drop = 1;
      else if (a == STAT && d[0]) m_drop = 0;
    end
  endtask

  task automatic rd(logic [23:0] a, string req);
    op(a, 0, 8'h00, req);
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(KEY, "R1"); rd(STAT, "R1"); rd(24'h300320, "R1"); rd(24'h30083E, "R1");
    // R4 locked write dropped, R10 flag sets, R8 read while locked
    op(24'h300320, 1, 8'hAA, "R4");
    rd(24'h300320, "R8");
    rd(STAT, "R10");
    op(STAT, 1, 8'hFE, "R10");
    rd(STAT, "R10");
    op(STAT, 1, 8'h01, "R10");
    rd(STAT, "R10");
    // R3 near-miss key value
    op(KEY, 1, 8'h95, "R3");
    op(24'h300805, 1, 8'h11, "R3");
    rd(24'h300805, "R3");
    op(STAT, 1, 8'h01, "R10");
    // R7 unlock then write in the very next cycle; R6 many writes
    op(KEY, 1, 8'h96, "R7");
    op(24'h30032C, 1, 8'h5C, "R7");
    for (int i = 0; i < 13; i++) op(24'h300320 + 24'(i), 1, 8'(8'h10 + i), "R6");
    for (int i = 0; i < 26; i++) op(24'h300800 + 24'(i), 1, 8'(8'h40 + i), "R6");
    op(24'h30083E, 1, 8'h3E, "R6");
    rd(KEY, "R2");
    // R5 neighbours of the guarded ranges
    op(24'h30031F, 1, 8'h01, "R5"); op(24'h30032D, 1, 8'h02, "R5");
    op(24'h3007FF, 1, 8'h03, "R5"); op(24'h30081A, 1, 8'h04, "R5");
    op(24'h30083D, 1, 8'h05, "R5");
    rd(24'h30081A, "R5");
    // R9 unguarded while unlocked
    op(24'h000010, 1, 8'h77, "R9");
    // R6 relock takes effect next cycle
    op(KEY, 1, 8'h00, "R6");
    op(24'h300810, 1, 8'hEE, "R6");
    op(24'h30083E, 1, 8'hEE, "R4");
    // R8 reads while locked
    for (int i = 0; i < 13; i++) rd(24'h300320 + 24'(i), "R8");
    for (int i = 0; i < 26; i++) rd(24'h300800 + 24'(i), "R8");
    rd(24'h30083E, "R8");
    // R9 unguarded while locked; R2 key writable while locked
    op(24'hABCDEF, 1, 8'h12, "R9");
    op(KEY, 1, 8'h5A, "R2");
    rd(KEY, "R2");
    rd(STAT, "R10");
    op(STAT, 1, 8'h03, "R10");
    rd(STAT, "R10");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule